// File: doc/BRIEF.md
# Multicycle Datapath Sequencing Controller

This block is the hardwired control unit for a multicycle load/store datapath that shares one memory and one ALU across the steps of an instruction. It holds a ten-state register and walks every instruction through fetch and decode, then down one of five paths chosen by the 6-bit opcode: load, store, register arithmetic, conditional branch, or jump. Loads take five cycles, stores and arithmetic take four, and branches and jumps take three.

Every datapath control output is decoded from the current state alone, so no opcode bit reaches an output in the same cycle. The opcode is read only in the decode state and the address-compute state. If an opcode that the controller does not know is seen in either of these, the controller goes back to fetch and raises a one-cycle error flag. A synchronous reset puts the controller in the fetch state.

Output encodings used throughout: `pc_src` 00 = ALU result, 01 = registered ALU result, 10 = jump target. `alu_mode` 00 = add, 01 = subtract, 10 = function field. `alu_b_sel` 00 = register B, 01 = constant 4, 10 = sign-extended immediate, 11 = shifted immediate. `alu_a_sel` 0 = PC, 1 = register A. Opcodes: 000000 arithmetic, 000010 jump, 000100 branch-if-equal, 100011 load, 101011 store.

Top module: `mcc_seq_ctrl`

## Requirements
- R1: While `rst` is high at a rising edge, the controller enters fetch on that edge, and `bad_op` is 0 in the cycle that follows.
- R2: Fetch drives `pc_wr_en`=1, `mem_rd`=1, `instr_ld`=1, `addr_sel_alu`=0, `alu_a_sel`=0, `alu_b_sel`=01, `alu_mode`=00, `pc_src`=00, and always moves to decode whatever the opcode.
- R3: Decode drives `alu_a_sel`=0, `alu_b_sel`=11, `alu_mode`=00. It moves to arithmetic execute on 000000, to jump on 000010, to branch on 000100, and to address compute on 100011 or 101011.
- R4: Address compute drives `alu_a_sel`=1, `alu_b_sel`=10, `alu_mode`=00. It moves to load-read on 100011 and to store-write on 101011.
- R5: Load-read drives `mem_rd`=1 and `addr_sel_alu`=1, then moves to load write-back. Load write-back drives `rf_wr`=1, `rf_dst_rd`=0, `wb_sel_mem`=1, then moves to fetch.
- R6: Store-write drives `mem_wr`=1 and `addr_sel_alu`=1, then moves to fetch.
- R7: Arithmetic execute drives `alu_a_sel`=1, `alu_b_sel`=00, `alu_mode`=10, then moves to arithmetic completion. Completion drives `rf_wr`=1, `rf_dst_rd`=1, `wb_sel_mem`=0, then moves to fetch.
- R8: Branch drives `alu_a_sel`=1, `alu_b_sel`=00, `alu_mode`=01, `pc_src`=01, `pc_wr_if_zero`=1. Jump drives `pc_src`=10 and `pc_wr_en`=1. Both move to fetch.
- R9: Each state drives `pc_wr_en`, `pc_wr_if_zero`, `instr_ld`, `mem_rd`, `mem_wr` and `rf_wr` to 0 unless its own requirement names them. Every select it does not name is 0. `mem_rd` and `mem_wr` are never high together.
- R10: An unlisted opcode seen in decode, or any opcode other than 100011 or 101011 seen in address compute, sends the controller to fetch. `bad_op` is then high for exactly that next cycle.
- R11: In every state other than decode and address compute, the opcode has no effect on the next state or on the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| opcode | input | 6 | Opcode field of the held instruction |
| pc_wr_en | output | 1 | Unconditional PC write |
| pc_wr_if_zero | output | 1 | PC write when the ALU zero flag is set |
| addr_sel_alu | output | 1 | Memory address from ALU register (1) or PC (0) |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| instr_ld | output | 1 | Instruction register load |
| wb_sel_mem | output | 1 | Register write data from memory data register (1) or ALU register (0) |
| pc_src | output | 2 | PC source select |
| alu_mode | output | 2 | ALU operation class |
| alu_b_sel | output | 2 | ALU second operand select |
| alu_a_sel | output | 1 | ALU first operand select |
| rf_wr | output | 1 | Register file write strobe |
| rf_dst_rd | output | 1 | Register write destination is the rd field (1) or rt (0) |
| bad_op | output | 1 | One-cycle unknown-opcode flag |

## Verification
The bench goes after opcodes that change between decode and address compute. A load dispatched from decode that sees a branch code one cycle later must be flagged. A controller that latched the opcode once would run a wrong memory phase instead. It also drives unrelated opcodes during the memory, write-back and completion states: if any of those states decoded the opcode, it would branch off its fixed path, and the per-cycle output vector would expose that. Reset is asserted in the middle of an instruction, and an error flag that stayed high for more than one cycle, or was raised on a legal opcode, shows up in the flag check of the next cycle.

// File: rtl/mcc_pkg.sv
package mcc_pkg;

    localparam int OPC_W = 6;
    localparam int SEL_W = 2;

    typedef enum logic [3:0] {
        ST_FETCH  = 4'd0,
        ST_DECODE = 4'd1,
        ST_ADDR   = 4'd2,
        ST_LDRD   = 4'd3,
        ST_LDWB   = 4'd4,
        ST_STWR   = 4'd5,
        ST_AEXE   = 4'd6,
        ST_AWB    = 4'd7,
        ST_BRN    = 4'd8,
        ST_JMP    = 4'd9
    } st_e;

    localparam logic [OPC_W-1:0] OP_ARITH = 6'b000000;
    localparam logic [OPC_W-1:0] OP_JUMP  = 6'b000010;
    localparam logic [OPC_W-1:0] OP_BEQ   = 6'b000100;
    localparam logic [OPC_W-1:0] OP_LOAD  = 6'b100011;
    localparam logic [OPC_W-1:0] OP_STORE = 6'b101011;

    typedef struct packed {
        logic             pc_wr;
        logic             pc_wr_cond;
        logic             addr_alu;
        logic             mem_rd;
        logic             mem_wr;
        logic             ir_ld;
        logic             wb_mem;
        logic [SEL_W-1:0] pc_src;
        logic [SEL_W-1:0] alu_mode;
        logic [SEL_W-1:0] b_sel;
        logic             a_sel;
        logic             rf_wr;
        logic             dst_rd;
    } ctl_t;

    typedef struct packed {
        st_e  st;
        logic bad;
    } seq_t;

endpackage

// File: rtl/mcc_next_state.sv
module mcc_next_state
    import mcc_pkg::*;
(
    input  st_e              st,
    input  logic [OPC_W-1:0] opcode,
    output st_e              st_nx,
    output logic             bad_nx
);
    always_comb begin
        st_nx  = ST_FETCH;
        bad_nx = 1'b0;
        unique case (st)
            ST_FETCH:  st_nx = ST_DECODE;
            ST_DECODE: begin
                if (opcode == OP_ARITH)      st_nx = ST_AEXE;
                else if (opcode == OP_JUMP)  st_nx = ST_JMP;
                else if (opcode == OP_BEQ)   st_nx = ST_BRN;
                else if (opcode == OP_LOAD || opcode == OP_STORE) st_nx = ST_ADDR;
                else                         bad_nx = 1'b1;
            end
            ST_ADDR: begin
                if (opcode == OP_LOAD)       st_nx = ST_LDRD;
                else if (opcode == OP_STORE) st_nx = ST_STWR;
                else                         bad_nx = 1'b1;
            end
            ST_LDRD:   st_nx = ST_LDWB;
            ST_AEXE:   st_nx = ST_AWB;
            ST_LDWB, ST_STWR, ST_AWB, ST_BRN, ST_JMP: st_nx = ST_FETCH;
            default:   st_nx = ST_FETCH;
        endcase
    end
endmodule

// File: rtl/mcc_out_decode.sv
module mcc_out_decode
    import mcc_pkg::*;
(
    input  st_e  st,
    output ctl_t ctl
);
    always_comb begin
        ctl = '0;
        unique case (st)
            ST_FETCH: begin
                ctl.pc_wr  = 1'b1;
                ctl.mem_rd = 1'b1;
                ctl.ir_ld  = 1'b1;
                ctl.b_sel  = 2'b01;
            end
            ST_DECODE: ctl.b_sel = 2'b11;
            ST_ADDR: begin
                ctl.a_sel = 1'b1;
                ctl.b_sel = 2'b10;
            end
            ST_LDRD: begin
                ctl.mem_rd   = 1'b1;
                ctl.addr_alu = 1'b1;
            end
            ST_LDWB: begin
                ctl.rf_wr  = 1'b1;
                ctl.wb_mem = 1'b1;
            end
            ST_STWR: begin
                ctl.mem_wr   = 1'b1;
                ctl.addr_alu = 1'b1;
            end
            ST_AEXE: begin
                ctl.a_sel    = 1'b1;
                ctl.alu_mode = 2'b10;
            end
            ST_AWB: begin
                ctl.rf_wr  = 1'b1;
                ctl.dst_rd = 1'b1;
            end
            ST_BRN: begin
                ctl.a_sel      = 1'b1;
                ctl.alu_mode   = 2'b01;
                ctl.pc_src     = 2'b01;
                ctl.pc_wr_cond = 1'b1;
            end
            ST_JMP: begin
                ctl.pc_src = 2'b10;
                ctl.pc_wr  = 1'b1;
            end
            default: ctl = '0;
        endcase
    end
endmodule

// File: rtl/mcc_seq_ctrl.sv
module mcc_seq_ctrl
    import mcc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [OPC_W-1:0] opcode,
    output logic             pc_wr_en,
    output logic             pc_wr_if_zero,
    output logic             addr_sel_alu,
    output logic             mem_rd,
    output logic             mem_wr,
    output logic             instr_ld,
    output logic             wb_sel_mem,
    output logic [SEL_W-1:0] pc_src,
    output logic [SEL_W-1:0] alu_mode,
    output logic [SEL_W-1:0] alu_b_sel,
    output logic             alu_a_sel,
    output logic             rf_wr,
    output logic             rf_dst_rd,
    output logic             bad_op
);
    seq_t seq_d, seq_q;
    st_e  st_nx;
    logic bad_nx;
    ctl_t ctl;

    mcc_next_state u_next (
        .st     (seq_q.st),
        .opcode (opcode),
        .st_nx  (st_nx),
        .bad_nx (bad_nx)
    );

    mcc_out_decode u_dec (
        .st  (seq_q.st),
        .ctl (ctl)
    );

    always_comb begin
        seq_d.st  = st_nx;
        seq_d.bad = bad_nx;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            seq_q.st  <= ST_FETCH;
            seq_q.bad <= 1'b0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign pc_wr_en      = ctl.pc_wr;
    assign pc_wr_if_zero = ctl.pc_wr_cond;
    assign addr_sel_alu  = ctl.addr_alu;
    assign mem_rd        = ctl.mem_rd;
    assign mem_wr        = ctl.mem_wr;
    assign instr_ld      = ctl.ir_ld;
    assign wb_sel_mem    = ctl.wb_mem;
    assign pc_src        = ctl.pc_src;
    assign alu_mode      = ctl.alu_mode;
    assign alu_b_sel     = ctl.b_sel;
    assign alu_a_sel     = ctl.a_sel;
    assign rf_wr         = ctl.rf_wr;
    assign rf_dst_rd     = ctl.dst_rd;
    assign bad_op        = seq_q.bad;
endmodule

// File: rtl/mcc_seq_ctrl_chk.sv
module mcc_seq_ctrl_chk
    import mcc_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic [OPC_W-1:0] opcode,
    input logic             pc_wr_en,
    input logic             pc_wr_if_zero,
    input logic             addr_sel_alu,
    input logic             mem_rd,
    input logic             mem_wr,
    input logic             instr_ld,
    input logic             wb_sel_mem,
    input logic [SEL_W-1:0] pc_src,
    input logic [SEL_W-1:0] alu_b_sel,
    input logic             rf_wr,
    input logic             bad_op
);
    // R1
    reset_to_fetch_chk: assert property (@(posedge clk)
        rst |=> (instr_ld && !bad_op));

    // R2
    fetch_then_decode_chk: assert property (@(posedge clk) disable iff (rst)
        instr_ld |=> (alu_b_sel == 2'b11));

    // R3
    decode_jump_chk: assert property (@(posedge clk) disable iff (rst)
        (alu_b_sel == 2'b11 && opcode == OP_JUMP) |=> (pc_src == 2'b10 && pc_wr_en));

    // R5
    load_wb_after_read_chk: assert property (@(posedge clk) disable iff (rst)
        (rf_wr && wb_sel_mem) |-> $past(mem_rd && addr_sel_alu));

    // R8
    branch_returns_chk: assert property (@(posedge clk) disable iff (rst)
        pc_wr_if_zero |=> instr_ld);

    // R9
    mem_excl_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({mem_rd, mem_wr}));

    // R10
    bad_in_fetch_chk: assert property (@(posedge clk) disable iff (rst)
        bad_op |-> (instr_ld && pc_wr_en));

    // R10
    bad_one_cycle_chk: assert property (@(posedge clk) disable iff (rst)
        bad_op |=> !bad_op);
endmodule

bind mcc_seq_ctrl mcc_seq_ctrl_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .opcode        (opcode),
    .pc_wr_en      (pc_wr_en),
    .pc_wr_if_zero (pc_wr_if_zero),
    .addr_sel_alu  (addr_sel_alu),
    .mem_rd        (mem_rd),
    .mem_wr        (mem_wr),
    .instr_ld      (instr_ld),
    .wb_sel_mem    (wb_sel_mem),
    .pc_src        (pc_src),
    .alu_b_sel     (alu_b_sel),
    .rf_wr         (rf_wr),
    .bad_op        (bad_op)
);

// File: tb/tb_mcc_seq_ctrl.sv
module tb_mcc_seq_ctrl;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [5:0] opcode = 6'd0;
    logic       pc_wr_en, pc_wr_if_zero, addr_sel_alu, mem_rd, mem_wr, instr_ld;
    logic       wb_sel_mem, alu_a_sel, rf_wr, rf_dst_rd, bad_op;
    logic [1:0] pc_src, alu_mode, alu_b_sel;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    int m_st   = 0;
    logic m_bad = 1'b0;
    logic m_valid = 1'b0;
    string tag_ovr = "";

    always #10 clk = ~clk;

    mcc_seq_ctrl dut (
        .clk(clk), .rst(rst), .opcode(opcode),
        .pc_wr_en(pc_wr_en), .pc_wr_if_zero(pc_wr_if_zero),
        .addr_sel_alu(addr_sel_alu), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .instr_ld(instr_ld), .wb_sel_mem(wb_sel_mem), .pc_src(pc_src),
        .alu_mode(alu_mode), .alu_b_sel(alu_b_sel), .alu_a_sel(alu_a_sel),
        .rf_wr(rf_wr), .rf_dst_rd(rf_dst_rd), .bad_op(bad_op)
    );

    // vector order: pc_wr, pc_wr_cond, addr_alu, mem_rd, mem_wr, ir_ld, wb_mem,
    // pc_src[2], alu_mode[2], b_sel[2], a_sel, rf_wr, dst_rd
    function automatic logic [15:0] exp_out(input int st);
        logic pw = 0, pc = 0, aa = 0, mr = 0, mw = 0, ir = 0, wm = 0, as = 0, rw = 0, dr = 0;
        logic [1:0] ps = 0, am = 0, bs = 0;
        case (st)
            0: begin pw = 1; mr = 1; ir = 1; bs = 2'b01; end
            1: bs = 2'b11;
            2: begin as = 1; bs = 2'b10; end
            3: begin mr = 1; aa = 1; end
            4: begin rw = 1; wm = 1; end
            5: begin mw = 1; aa = 1; end
            6: begin as = 1; am = 2'b10; end
            7: begin rw = 1; dr = 1; end
            8: begin as = 1; am = 2'b01; ps = 2'b01; pc = 1; end
            9: begin ps = 2'b10; pw = 1; end
            default: ;
        endcase
        return {pw, pc, aa, mr, mw, ir, wm, ps, am, bs, as, rw, dr};
    endfunction

    function automatic int exp_next(input int st, input logic [5:0] op, output logic bad);
        bad = 1'b0;
        case (st)
            0: return 1;
            1: begin
                if (op == 6'b000000) return 6;
                if (op == 6'b000010) return 9;
                if (op == 6'b000100) return 8;
                if (op == 6'b100011 || op == 6'b101011) return 2;
                bad = 1'b1; return 0;
            end
            2: begin
                if (op == 6'b100011) return 3;
                if (op == 6'b101011) return 5;
                bad = 1'b1; return 0;
            end
            3: return 4;
            6: return 7;
            default: return 0;
        endcase
    endfunction

    function automatic string req_of(input int st);
        case (st)
            0: return "R2";
            1: return "R3";
            2: return "R4";
            3, 4: return "R5";
            5: return "R6";
            6, 7: return "R7";
            default: return "R8";
        endcase
    endfunction

    task automatic check_now();
        logic [15:0] act, exp;
        string t;
        if (!m_valid) return;
        act = {pc_wr_en, pc_wr_if_zero, addr_sel_alu, mem_rd, mem_wr, instr_ld, wb_sel_mem,
               pc_src, alu_mode, alu_b_sel, alu_a_sel, rf_wr, rf_dst_rd};
        exp = exp_out(m_st);
        t = (tag_ovr != "") ? tag_ovr : req_of(m_st);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: outputs act=%h exp=%h (state %0d)", t, act, exp, m_st);
        end
        checks++;
        if (bad_op !== m_bad) begin
            errors++;
            $display("FAIL R10: bad_op act=%b exp=%b", bad_op, m_bad);
        end
        if (m_st != 0 && m_st != 9) begin
            checks++;
            if (pc_wr_en !== 1'b0 || instr_ld !== 1'b0 || (m_st != 8 && pc_wr_if_zero !== 1'b0)) begin
                errors++;
                $display("FAIL R9: strobes act=%b%b%b exp=000", pc_wr_en, instr_ld, pc_wr_if_zero);
            end
        end
        tag_ovr = "";
    endtask

    task automatic tick(input logic [5:0] op, input logic r);
        logic b;
        @(negedge clk);
        check_now();
        opcode = op;
        rst = r;
        if (r) begin
            m_st = 0; m_bad = 1'b0;
        end else begin
            m_st = exp_next(m_st, op, b);
            m_bad = b;
        end
        m_valid = 1'b1;
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++;
            $display("FAIL watchdog: act=hung exp=done");
            finish_run();
        end
    end

    function automatic logic [5:0] pick_op();
        int unsigned r = $urandom % 12;
        case (r)
            0, 1: return 6'b000000;
            2, 3: return 6'b100011;
            4, 5: return 6'b101011;
            6: return 6'b000100;
            7: return 6'b000010;
            default: return 6'($urandom);
        endcase
    endfunction

    initial begin
        int unsigned seed_init;
        seed_init = $urandom(32'd4242);
        // R1: reset from time zero
        tick(6'h3f, 1'b1);
        tick(6'h3f, 1'b1);
        tag_ovr = "R1";
        tick(6'b100011, 1'b0);          // fetch checked under R1
        tick(6'b100011, 1'b0);          // decode: load
        tick(6'b100011, 1'b0);          // addr: load
        tag_ovr = "R11";
        tick(6'b000100, 1'b0);          // load-read ignores opcode
        tag_ovr = "R11";
        tick(6'h3f, 1'b0);              // write-back ignores opcode
        // store
        tick(6'b101011, 1'b0);
        tick(6'b101011, 1'b0);
        tick(6'b101011, 1'b0);
        tick(6'b000010, 1'b0);
        // R10: opcode changes between decode and address compute
        tick(6'b100011, 1'b0);
        tick(6'b100011, 1'b0);
        tick(6'b000100, 1'b0);
        tag_ovr = "R10";
        tick(6'b000000, 1'b0);          // fetch with flag
        // R10: unknown opcode at decode
        tick(6'h3f, 1'b0);
        tick(6'h00, 1'b0);              // fetch, flag, then arithmetic next
        tick(6'b000000, 1'b0);
        tick(6'b000100, 1'b0);
        tick(6'h15, 1'b0);
        // R1: reset mid-instruction
        tick(6'b000010, 1'b0);
        tick(6'b000000, 1'b0);
        tick(6'b000000, 1'b1);
        tag_ovr = "R1";
        tick(6'b000100, 1'b0);
        for (int i = 0; i < 3000; i++) begin
            tick(pick_op(), ($urandom % 400) == 0);
        end
        tick(6'd0, 1'b0);
        finish_run();
    end
endmodule